// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer Channel

This block is a single channel of an interval timer. It keeps a reload register value, supplied from outside, and a down-counter of the same width. One counter serves four behaviours. Periodic mode counts the whole width. Split mode counts the low half to zero and then the high half. Accumulate mode steps only on trigger events. Capture mode free-runs from all ones and records the inverted count when a trigger arrives.

A register interface outside the block drives the enable, the mode and option bits and the reload value. Interrupt logic outside the block consumes the timeout pulse and the flag-set request. The chain input comes from the previous channel's timeout pulse. Triggers arrive already selected by an external multiplexer, and the block reacts to their rising edges.

Top module: `ivt_channel`

## Requirements
- R1: After reset, count, capture value, timeout pulse, flag-set request and pre-trigger are all zero.
- R2: In periodic mode (mode_sel = 0) a rising enable loads the reload value at the next clock edge. Each enabled tick then decrements the count, and a timeout occurs on the step that finds the count at zero, which also reloads it. The timeout period is therefore reload + 1 ticks.
- R3: A new reload value does not disturb the running period. It is first used when the current period expires.
- R4: In split mode (mode_sel = 1), steps decrement the low half (bits 15:0) until it reaches zero. The high half (bits 31:16) then counts down. The pre-trigger output is high from the step that brings the low half to zero until the timeout, which clears it. The period is low + high + 1 steps. Pre-trigger is low in every other mode.
- R5: In accumulate mode (mode_sel = 2) the counter loads the reload value on the first trigger edge after enable. It then decrements once per trigger edge, ignores ticks, and times out on the trigger that finds zero.
- R6: In capture mode (mode_sel = 3) the counter loads all ones and decrements on ticks. A trigger edge stores the bitwise inverse of the current count in the capture value.
- R7: A timeout raises timeout_pulse for exactly one cycle, with flag_set_req high in the same cycle.
- R8: With start_on_trig set, an enabled channel holds its loaded count until a trigger edge. That edge reloads the count, and counting starts on the following steps.
- R9: With stop_on_timeout set, the channel reloads at timeout and then stops: active drops, the count is frozen and no further timeouts occur while enable stays high.
- R10: With reload_on_trig set, a trigger edge in a counting mode reloads the count in place of a step.
- R11: With chain_mode set, the channel steps once per cycle that chain_in is high and ignores tick_en.
- R12: While enable is low the count is frozen. A later rising enable reloads it.
- R13: Triggers are edge detected: a trigger held high for several cycles acts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel enable; the rising edge loads the counter |
| tick_en | input | 1 | Count tick qualifier |
| trig_in | input | 1 | Selected trigger level |
| chain_in | input | 1 | Timeout pulse of the previous channel |
| mode_sel | input | 2 | 0 periodic, 1 split, 2 accumulate, 3 capture |
| start_on_trig | input | 1 | Wait for a trigger before counting |
| stop_on_timeout | input | 1 | Stop after the first timeout |
| reload_on_trig | input | 1 | Trigger reloads the counter |
| chain_mode | input | 1 | Step on chain_in instead of tick_en |
| reload_val | input | CNT_W | Reload value |
| count | output | CNT_W | Current counter value |
| timeout_pulse | output | 1 | One-cycle timeout pulse |
| flag_set_req | output | 1 | Request to set the timeout flag |
| pretrig | output | 1 | Split-mode pre-trigger level |
| capture_val | output | CNT_W | Inverted count captured on trigger |
| active | output | 1 | Channel is waiting or counting |

## Verification
The hardest states to reach are the stop-after-timeout hold and the split-mode window in which the pre-trigger is high. Both exist only for a few cycles that depend on the reload value. The stimulus uses small reload values and a cycle counter, so each timeout can be booked into the scoreboard before it happens. The pre-trigger is sampled at the exact cycles where it must rise and fall. In the held-stop case the bench waits far longer than one period, so that any stray timeout would show up as an unexpected pulse.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
   typedef enum logic [1:0] {
      MODE_PER32 = 2'd0,
      MODE_SPLIT = 2'd1,
      MODE_ACCUM = 2'd2,
      MODE_CAPT  = 2'd3
   } ivt_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RUN  = 2'd2,
      ST_HALT = 2'd3
   } ivt_state_e;
endpackage

// File: rtl/ivt_edge_det.sv
module ivt_edge_det #(
   parameter bit RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_in,
   output logic edge_out
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_in;
   end

   generate
      if (RISE) begin : g_rise
         assign edge_out = lvl_in & ~lvl_q;
      end else begin : g_fall
         assign edge_out = ~lvl_in & lvl_q;
      end
   endgenerate

   // R13: one edge per held level
   AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      edge_out |=> !edge_out); // R13
endmodule

// File: rtl/ivt_step_sel.sv
module ivt_step_sel #(
   parameter bit CHAIN_EN = 1'b1
) (
   input  logic       accum_mode,
   input  logic       chain_mode,
   input  logic       tick_en,
   input  logic       chain_in,
   input  logic       trig_edge,
   output logic       step
);
   logic base_step;

   generate
      if (CHAIN_EN) begin : g_chain
         assign base_step = chain_mode ? chain_in : tick_en;
      end else begin : g_nochain
         logic unused_chain;
         assign unused_chain = chain_mode ^ chain_in;
         assign base_step    = tick_en;
      end
   endgenerate

   assign step = accum_mode ? trig_edge : base_step;
endmodule

// File: rtl/ivt_capture.sv
module ivt_capture #(
   parameter int W      = 32,
   parameter bit CAP_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         strobe,
   input  logic [W-1:0] cnt,
   output logic [W-1:0] cap
);
   generate
      if (CAP_EN) begin : g_cap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cap <= '0;
            else if (strobe) cap <= ~cnt;
         end

         AST_CAPTURE_INV: assert property (@(posedge clk) disable iff (!rst_n)
            strobe |=> cap == ~$past(cnt)); // R6
      end else begin : g_nocap
         logic unused_cap;
         assign unused_cap = strobe ^ (^cnt) ^ clk ^ rst_n;
         assign cap        = '0;
      end
   endgenerate
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
   import ivt_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter bit CHAIN_EN = 1'b1,
   parameter bit CAP_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             tick_en,
   input  logic             trig_in,
   input  logic             chain_in,
   input  logic [1:0]       mode_sel,
   input  logic             start_on_trig,
   input  logic             stop_on_timeout,
   input  logic             reload_on_trig,
   input  logic             chain_mode,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] count,
   output logic             timeout_pulse,
   output logic             flag_set_req,
   output logic             pretrig,
   output logic [CNT_W-1:0] capture_val,
   output logic             active
);
   localparam int HALF_W = CNT_W / 2;

   generate
      if ((CNT_W % 2) != 0 || CNT_W < 4) begin : g_bad_width
         $error("ivt_channel: CNT_W must be even and at least 4");
      end
   endgenerate

   ivt_mode_e        mode;
   ivt_state_e       state_q;
   logic [CNT_W-1:0] cnt_q, load_val, dec_val;
   logic             en_q, en_rise, trig_edge, step, expire;
   logic             pulse_q, flag_q, pre_q, cap_strobe;
   logic [HALF_W-1:0] lo_half, hi_half;

   assign mode     = ivt_mode_e'(mode_sel);
   assign en_rise  = enable & ~en_q;
   assign load_val = (mode == MODE_CAPT) ? {CNT_W{1'b1}} : reload_val;
   assign lo_half  = cnt_q[HALF_W-1:0];
   assign hi_half  = cnt_q[CNT_W-1:HALF_W];
   assign expire   = (cnt_q == '0);

   always_comb begin
      if (mode == MODE_SPLIT) begin
         if (lo_half != '0) dec_val = {hi_half, lo_half - 1'b1};
         else               dec_val = {hi_half - 1'b1, lo_half};
      end else begin
         dec_val = cnt_q - 1'b1;
      end
   end

   ivt_edge_det #(.RISE(1'b1)) u_trig_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_in   (trig_in),
      .edge_out (trig_edge)
   );

   ivt_step_sel #(.CHAIN_EN(CHAIN_EN)) u_step_sel (
      .accum_mode (mode == MODE_ACCUM),
      .chain_mode (chain_mode),
      .tick_en    (tick_en),
      .chain_in   (chain_in),
      .trig_edge  (trig_edge),
      .step       (step)
   );

   assign cap_strobe = enable && (state_q == ST_RUN) && (mode == MODE_CAPT) && trig_edge;

   ivt_capture #(.W(CNT_W), .CAP_EN(CAP_EN)) u_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (cap_strobe),
      .cnt    (cnt_q),
      .cap    (capture_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         pulse_q <= 1'b0;
         flag_q  <= 1'b0;
         pre_q   <= 1'b0;
      end else begin
         en_q    <= enable;
         pulse_q <= 1'b0;
         flag_q  <= 1'b0;
         if (mode != MODE_SPLIT) pre_q <= 1'b0;
         if (!enable) begin
            state_q <= ST_IDLE;
            pre_q   <= 1'b0;
         end else if (en_rise) begin
            cnt_q   <= load_val;
            pre_q   <= 1'b0;
            state_q <= (start_on_trig || mode == MODE_ACCUM) ? ST_WAIT : ST_RUN;
         end else begin
            unique case (state_q)
               ST_WAIT: begin
                  if (trig_edge) begin
                     cnt_q   <= load_val;
                     state_q <= ST_RUN;
                  end
               end
               ST_RUN: begin
                  if (reload_on_trig && trig_edge && mode != MODE_ACCUM) begin
                     cnt_q <= load_val;
                     pre_q <= 1'b0;
                  end else if (step) begin
                     if (expire) begin
                        cnt_q   <= load_val;
                        pulse_q <= 1'b1;
                        flag_q  <= 1'b1;
                        pre_q   <= 1'b0;
                        if (stop_on_timeout) state_q <= ST_HALT;
                     end else begin
                        cnt_q <= dec_val;
                        if (mode == MODE_SPLIT)
                           pre_q <= (dec_val[HALF_W-1:0] == '0);
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign count         = cnt_q;
   assign timeout_pulse = pulse_q;
   assign flag_set_req  = flag_q;
   assign pretrig       = pre_q;
   assign active        = (state_q == ST_WAIT) || (state_q == ST_RUN);

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_pulse && reload_val > 1) |=> !timeout_pulse); // R7
   AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_pulse) |-> flag_set_req); // R7
   AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> $stable(count)); // R12
   AST_LOAD_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (en_rise && mode != MODE_CAPT) |=> count == $past(reload_val)); // R2
   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT && enable) |=> ($stable(count) && !timeout_pulse)); // R9
   AST_PRETRIG_SPLIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MODE_SPLIT) |=> !pretrig); // R4
   AST_ACCUM_IGNORES_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_ACCUM && state_q == ST_RUN && enable && !trig_edge) |=> $stable(count)); // R5
endmodule

// File: tb/ivt_channel_tb.sv
module ivt_channel_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0, tick_en = 1'b0, trig_in = 1'b0, chain_in = 1'b0;
   logic [1:0]  mode_sel = 2'd0;
   logic        start_on_trig = 1'b0, stop_on_timeout = 1'b0;
   logic        reload_on_trig = 1'b0, chain_mode = 1'b0;
   logic [31:0] reload_val = 32'd0;
   logic [31:0] count, capture_val;
   logic        timeout_pulse, flag_set_req, pretrig, active;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int exp_q[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ivt_channel dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tick_en(tick_en),
      .trig_in(trig_in), .chain_in(chain_in), .mode_sel(mode_sel),
      .start_on_trig(start_on_trig), .stop_on_timeout(stop_on_timeout),
      .reload_on_trig(reload_on_trig), .chain_mode(chain_mode),
      .reload_val(reload_val), .count(count), .timeout_pulse(timeout_pulse),
      .flag_set_req(flag_set_req), .pretrig(pretrig),
      .capture_val(capture_val), .active(active)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain(input string req);
      chk(req, exp_q.size(), 0);
      exp_q.delete();
   endtask

   // Scoreboard monitor: every timeout must match the next booked cycle (R7)
   always @(negedge clk) begin
      if (rst_n && timeout_pulse) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R7 unexpected timeout: actual cycle %0d expected none", cyc);
         end else begin
            if (exp_q[0] != cyc || flag_set_req !== 1'b1) begin
               errors++;
               $display("FAIL R7 timeout: actual cycle %0d flag %0b expected cycle %0d flag 1",
                        cyc, flag_set_req, exp_q[0]);
            end
            void'(exp_q.pop_front());
         end
      end
   end

   initial begin
      int c;
      logic [31:0] v;
      fork
         begin
            step(3);
            rst_n = 1'b1;
            step(1);
            // R1 reset state
            chk("R1 count", count, 0);
            chk("R1 flags", {timeout_pulse, flag_set_req, pretrig}, 0);
            chk("R1 capture", capture_val, 0);

            // R2 / R3 periodic and reload update
            tick_en = 1'b1; reload_val = 32'd4; mode_sel = 2'd0;
            c = cyc; enable = 1'b1;
            exp_q.push_back(c + 6);
            step(1); chk("R2 load", count, 4);
            step(1); chk("R2 decrement", count, 3);
            step(4);                        // cycle c+6, timeout seen
            reload_val = 32'd7;
            exp_q.push_back(c + 11);
            exp_q.push_back(c + 19);
            step(6); chk("R3 new reload at expiry", count, 6);
            step(8); drain("R3 periodic");

            // R12 freeze and reload on re-enable
            v = count; enable = 1'b0;
            step(3); chk("R12 frozen", count, v);
            enable = 1'b1;
            step(1); chk("R12 reload", count, 7);
            enable = 1'b0; step(2);

            // R4 split mode: low 3, high 2
            mode_sel = 2'd1; reload_val = {16'd2, 16'd3};
            c = cyc; enable = 1'b1; exp_q.push_back(c + 7);
            step(3); chk("R4 pretrig low", pretrig, 0);
            step(1); chk("R4 pretrig rise", pretrig, 1);
            step(2); chk("R4 pretrig held", pretrig, 1);
                     chk("R4 high half", count, 32'h0000_0000);
            step(1); chk("R4 pretrig clear", pretrig, 0);
            enable = 1'b0; step(2); drain("R4 split");

            // R5 / R13 accumulate
            mode_sel = 2'd2; reload_val = 32'd3; enable = 1'b1;
            step(3); chk("R5 ticks ignored", count, 3);
            trig_in = 1'b1; step(1); trig_in = 1'b0; step(1);
            chk("R5 first trigger loads", count, 3);
            trig_in = 1'b1; step(3); trig_in = 1'b0; step(1);
            chk("R13 held trigger once", count, 2);
            trig_in = 1'b1; step(1); trig_in = 1'b0; step(1);
            trig_in = 1'b1; step(1); trig_in = 1'b0; step(1);
            chk("R5 reached zero", count, 0);
            exp_q.push_back(cyc + 1);
            trig_in = 1'b1; step(1); trig_in = 1'b0; step(1);
            chk("R5 reload after timeout", count, 3);
            enable = 1'b0; step(2); drain("R5 accumulate");

            // R6 capture
            mode_sel = 2'd3; c = cyc; enable = 1'b1;
            step(1); chk("R6 loads all ones", count, 32'hFFFF_FFFF);
            step(9); trig_in = 1'b1; step(1); trig_in = 1'b0;
            chk("R6 capture first", capture_val, 9);
            step(5); trig_in = 1'b1; step(1); trig_in = 1'b0;
            chk("R6 capture second", capture_val, 15);
            enable = 1'b0; step(2);

            // R8 start on trigger
            mode_sel = 2'd0; reload_val = 32'd5; start_on_trig = 1'b1;
            c = cyc; enable = 1'b1;
            step(4); chk("R8 waits", count, 5);
            exp_q.push_back(c + 11);
            trig_in = 1'b1; step(1); trig_in = 1'b0;
            step(7); chk("R8 counting after timeout", count, 4);
            enable = 1'b0; start_on_trig = 1'b0; step(2); drain("R8 start");

            // R9 stop on timeout
            reload_val = 32'd3; stop_on_timeout = 1'b1;
            c = cyc; enable = 1'b1; exp_q.push_back(c + 5);
            step(6); chk("R9 inactive", active, 0);
                     chk("R9 reloaded", count, 3);
            step(10); chk("R9 still frozen", count, 3);
            enable = 1'b0; stop_on_timeout = 1'b0; step(2); drain("R9 stop");

            // R10 reload on trigger
            reload_val = 32'd6; reload_on_trig = 1'b1;
            c = cyc; enable = 1'b1;
            step(4); chk("R10 before trigger", count, 3);
            exp_q.push_back(c + 12);
            trig_in = 1'b1; step(1); trig_in = 1'b0;
            chk("R10 reloaded", count, 6);
            step(8); enable = 1'b0; reload_on_trig = 1'b0; step(2); drain("R10 reload");

            // R11 chaining
            reload_val = 32'd2; chain_mode = 1'b1; enable = 1'b1;
            step(5); chk("R11 ticks ignored", count, 2);
            chain_in = 1'b1; step(1); chain_in = 1'b0; step(1);
            chk("R11 chain step", count, 1);
            chain_in = 1'b1; step(1); chain_in = 1'b0; step(1);
            chk("R11 chain zero", count, 0);
            exp_q.push_back(cyc + 1);
            chain_in = 1'b1; step(1); chain_in = 1'b0; step(1);
            chk("R11 chain reload", count, 2);
            enable = 1'b0; chain_mode = 1'b0; step(2); drain("R11 chain");
         end
         begin
            step(20000);
            errors++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule